// File: doc/BRIEF.md
# Outstanding-Request Watchdog

This block counts the flagged transmit requests that are in flight and protects all of them with one shared timeout. Each enqueue strobe adds one to the count and each dequeue strobe removes one. The first request that arrives on an empty count starts the timer with the full interval. Every completion that still leaves work pending restarts the timer, and the completion that empties the count stops it.

If the timer runs out while requests are still outstanding, the block raises a one-cycle cancel-all pulse and a one-cycle link hold-down request. A separate agent acts on those pulses. The interval is a port counted in clock cycles. A package helper gives the nominal interval for a given tick rate, which is one twentieth of a second rounded up to a whole tick.

A synchronous flush input empties the count and stops the timer without raising any pulse.

Top module: `outstanding_watchdog`

## Requirements
- R1: After reset, the count is 0 and both `cancel_pulse` and `hold_req` are low.
- R2: An enqueue on a zero count arms the timer with the full interval I. With no further strobes, `cancel_pulse` and `hold_req` go high together exactly I cycles after the enqueue edge and stay high for one cycle only.
- R3: An enqueue on a nonzero count increments the count and leaves the running timer alone, so expiry stays referenced to the first enqueue.
- R4: A dequeue that leaves the count nonzero decrements the count and reloads the timer, so expiry falls I cycles after that dequeue edge.
- R5: A dequeue that brings the count to zero disarms the timer, and no pulse follows.
- R6: Enqueue and dequeue in the same cycle leave the count unchanged. If the timer is armed, it is reloaded. If it is idle, it stays idle.
- R7: Flush forces the count to 0 and disarms the timer, and it never produces a pulse. Flush has priority over enqueue and dequeue.
- R8: The count saturates at its maximum value (2^CNT_W-1) on further enqueues. A dequeue at count 0 is ignored.
- R9: An interval value of 0 is treated as 1.
- R10: After expiry, the count is kept and the timer stays idle. A later enqueue does not rearm it. A later dequeue that leaves requests pending does rearm it.
- R11: The package helper `nominal_ticks(hz)` returns ceil(hz/20).
- R12: The interval is sampled only when the timer is armed or reloaded. Changing it while the timer runs does not move the expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq | input | 1 | One request issued |
| deq | input | 1 | One request completed |
| flush | input | 1 | Drop all tracking without a pulse |
| interval | input | TMR_W | Timeout length in clock cycles |
| cancel_pulse | output | 1 | One-cycle cancel-all request on expiry |
| hold_req | output | 1 | One-cycle link hold-down request on expiry |
| out_count | output | CNT_W | Outstanding request count |

## Verification
The count and the timer commands are registered once, so `out_count` reflects a strobe one edge after it is sampled. The expiry pulse is due exactly I edges after the edge that armed or reloaded the timer. The bench drives inputs on falling edges and reads outputs on the following falling edge. It measures expiry as a number of whole cycles from the arming edge and compares that with I for every interval from 0 to 6. For the cases where no pulse may occur, it scans a window well beyond the interval and checks that no pulse appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Strobes seen in one cycle
    typedef struct packed {
        logic add;
        logic drop;
        logic clear;
    } req_evt_t;

    // Command from the decision logic to the countdown timer
    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_RUN  = 2'd1,
        TM_LOAD = 2'd2,
        TM_STOP = 2'd3
    } tmr_cmd_e;

    // Nominal interval: one twentieth of a second, rounded up to a tick
    function automatic int unsigned nominal_ticks(input int unsigned hz);
        return (hz + 19) / 20;
    endfunction

    // Timer action from this cycle's strobes and the pre-update state
    function automatic tmr_cmd_e decide_cmd(input req_evt_t ev,
                                            input logic cnt_zero,
                                            input logic cnt_one,
                                            input logic armed);
        tmr_cmd_e c;
        if (ev.clear) begin
            c = TM_STOP;
        end else if (ev.add && !ev.drop) begin
            if (cnt_zero)   c = TM_LOAD;
            else if (armed) c = TM_RUN;
            else            c = TM_IDLE;
        end else if (ev.drop && !ev.add) begin
            if (cnt_zero)     c = armed ? TM_RUN : TM_IDLE;
            else if (cnt_one) c = TM_STOP;
            else              c = TM_LOAD;
        end else if (ev.add && ev.drop) begin
            c = armed ? TM_LOAD : TM_IDLE;
        end else begin
            if (!armed)        c = TM_IDLE;
            else if (cnt_zero) c = TM_STOP;
            else               c = TM_RUN;
        end
        return c;
    endfunction

endpackage

// File: rtl/req_counter.sv
module req_counter
    import wdog_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  req_evt_t      evt,
    output logic [CW-1:0] count,
    output logic          is_zero,
    output logic          is_one
);
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (evt.clear) begin
            cnt_q <= '0;
        end else if (evt.add && !evt.drop) begin
            if (cnt_q != MAXV) cnt_q <= cnt_q + ONE;
        end else if (evt.drop && !evt.add) begin
            if (cnt_q != '0) cnt_q <= cnt_q - ONE;
        end
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == ONE);

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAXV && evt.add && !evt.drop && !evt.clear) |=> (cnt_q == MAXV));
endmodule

// File: rtl/expiry_timer.sv
module expiry_timer
    import wdog_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  tmr_cmd_e      cmd,
    input  logic [TW-1:0] interval,
    output logic          armed,
    output logic          expire
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] rem_q;
    logic          armed_q;
    logic          exp_q;
    logic [TW-1:0] load_val;

    assign load_val = (interval == '0) ? ONE : interval;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            armed_q <= 1'b0;
            exp_q   <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            unique case (cmd)
                TM_LOAD: begin
                    armed_q <= 1'b1;
                    rem_q   <= load_val;
                end
                TM_STOP: begin
                    armed_q <= 1'b0;
                    rem_q   <= '0;
                end
                TM_RUN: begin
                    if (rem_q == ONE) begin
                        armed_q <= 1'b0;
                        rem_q   <= '0;
                        exp_q   <= 1'b1;
                    end else begin
                        rem_q <= rem_q - ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign armed  = armed_q;
    assign expire = exp_q;

    // R2
    armed_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (rem_q != '0));
endmodule

// File: rtl/outstanding_watchdog.sv
module outstanding_watchdog
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq,
    input  logic             deq,
    input  logic             flush,
    input  logic [TMR_W-1:0] interval,
    output logic             cancel_pulse,
    output logic             hold_req,
    output logic [CNT_W-1:0] out_count
);
    req_evt_t      evt;
    tmr_cmd_e      cmd;
    logic          cnt_zero;
    logic          cnt_one;
    logic          armed;
    logic          expire;

    assign evt = '{add: enq, drop: deq, clear: flush};
    assign cmd = decide_cmd(evt, cnt_zero, cnt_one, armed);

    req_counter #(.CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .count   (out_count),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    expiry_timer #(.TW(TMR_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .interval (interval),
        .armed    (armed),
        .expire   (expire)
    );

    assign cancel_pulse = expire;
    assign hold_req     = expire;

    // R2
    pulse_needs_work_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_pulse |-> (out_count != '0));
    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_pulse |=> !cancel_pulse);
    // R5
    idle_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (out_count == '0) |-> !armed);
    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (out_count == '0 && !cancel_pulse));
    // R6
    paired_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (enq && deq && !flush) |=> $stable(out_count));
endmodule

// File: tb/outstanding_watchdog_bench.sv
module outstanding_watchdog_bench;
    import wdog_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 3;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq = 1'b0;
    logic          deq = 1'b0;
    logic          flush = 1'b0;
    logic [TW-1:0] interval = TW'(5);
    logic          cancel_pulse;
    logic          hold_req;
    logic [CW-1:0] out_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    outstanding_watchdog #(.CNT_W(CW), .TMR_W(TW)) u_outstanding_watchdog (
        .clk(clk), .rst(rst), .enq(enq), .deq(deq), .flush(flush),
        .interval(interval), .cancel_pulse(cancel_pulse),
        .hold_req(hold_req), .out_count(out_count)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive on falling edge; the following rising edge samples; return at next falling edge
    task automatic tick(input logic e, input logic d, input logic f);
        enq = e; deq = d; flush = f;
        @(posedge clk);
        @(negedge clk);
        enq = 1'b0; deq = 1'b0; flush = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick(0, 0, 0);
        tick(0, 0, 0);
        rst = 1'b0;
    endtask

    // Cycles from the last stimulus edge to the pulse, -1 if none within lim
    task automatic wait_cancel(input int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            tick(0, 0, 0);
            if (cancel_pulse) begin
                n = i;
                break;
            end
        end
    endtask

    int n;

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 count", int'(out_count), 0);
        chk("R1 cancel", int'(cancel_pulse), 0);
        chk("R1 hold", int'(hold_req), 0);

        // R2 sweep of intervals, R9 covers interval 0
        for (int iv = 0; iv <= 6; iv++) begin
            do_reset();
            interval = TW'(iv);
            tick(1, 0, 0);
            chk("R2 count after enq", int'(out_count), 1);
            wait_cancel(20, n);
            chk(iv == 0 ? "R9 zero interval" : "R2 expiry delay", n, iv == 0 ? 1 : iv);
            chk("R2 hold with cancel", int'(hold_req), 1);
            tick(0, 0, 0);
            chk("R2 one cycle pulse", int'(cancel_pulse), 0);
            chk("R2 hold one cycle", int'(hold_req), 0);
        end

        // R3 second enqueue does not restart
        do_reset();
        interval = TW'(6);
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(1, 0, 0);
        chk("R3 count", int'(out_count), 2);
        wait_cancel(20, n);
        chk("R3 expiry from first enq", n, 4);

        // R4 sweep: partial dequeue reloads
        for (int iv = 1; iv <= 6; iv++) begin
            do_reset();
            interval = TW'(iv);
            tick(1, 0, 0);
            tick(1, 0, 0);
            if (iv > 2) tick(0, 0, 0);
            tick(0, 1, 0);
            chk("R4 count after deq", int'(out_count), 1);
            wait_cancel(20, n);
            chk("R4 expiry after reload", n, iv);
        end

        // R5 last dequeue disarms
        do_reset();
        interval = TW'(4);
        tick(1, 0, 0);
        tick(0, 1, 0);
        chk("R5 count", int'(out_count), 0);
        wait_cancel(20, n);
        chk("R5 no pulse", n, -1);

        // R6 paired strobes while armed reload, count unchanged
        do_reset();
        interval = TW'(5);
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        tick(1, 1, 0);
        chk("R6 count unchanged", int'(out_count), 1);
        wait_cancel(20, n);
        chk("R6 reload", n, 5);
        // R6 paired strobes while idle stay idle
        do_reset();
        tick(1, 1, 0);
        chk("R6 idle count", int'(out_count), 0);
        wait_cancel(20, n);
        chk("R6 idle no pulse", n, -1);

        // R7 flush, with priority over enq
        do_reset();
        interval = TW'(4);
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(1, 0, 1);
        chk("R7 flush count", int'(out_count), 0);
        chk("R7 flush no cancel", int'(cancel_pulse), 0);
        wait_cancel(20, n);
        chk("R7 disarmed", n, -1);

        // R8 saturation and dequeue at zero
        do_reset();
        interval = TW'(100);
        for (int i = 0; i < 10; i++) tick(1, 0, 0);
        chk("R8 saturate", int'(out_count), (1 << CW) - 1);
        tick(0, 0, 1);
        tick(0, 1, 0);
        chk("R8 deq at zero", int'(out_count), 0);
        chk("R8 no pulse", int'(cancel_pulse), 0);

        // R10 after expiry
        do_reset();
        interval = TW'(3);
        tick(1, 0, 0);
        tick(1, 0, 0);
        wait_cancel(20, n);
        chk("R10 first expiry", n, 2);
        chk("R10 count kept", int'(out_count), 2);
        wait_cancel(10, n);
        chk("R10 stays idle", n, -1);
        tick(1, 0, 0);
        chk("R10 count after enq", int'(out_count), 3);
        wait_cancel(10, n);
        chk("R10 enq no rearm", n, -1);
        tick(0, 1, 0);
        chk("R10 count after deq", int'(out_count), 2);
        wait_cancel(10, n);
        chk("R10 deq rearms", n, 3);

        // R12 interval sampled at arm time
        do_reset();
        interval = TW'(4);
        tick(1, 0, 0);
        interval = TW'(10);
        wait_cancel(20, n);
        chk("R12 interval latched", n, 4);

        // R11 nominal interval helper
        for (int hz = 1; hz <= 60; hz += 7) begin
            chk("R11 nominal ticks", int'(nominal_ticks(hz)),
                (hz % 20 == 0) ? hz / 20 : hz / 20 + 1);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule